// File: doc/BRIEF.md
# Fetch-Stage Branch Target Buffer

This block sits beside the instruction memory in the fetch stage and is looked up with the same program counter, in the same cycle. Each entry holds the full address of a branch, a two-bit saturating confidence counter and the branch destination. If the current fetch address matches an entry and that entry's counter has its upper bit set, the block offers the stored destination as the next fetch address. Fetch then follows a predicted-taken branch without waiting for decode. In every other case the block offers the sequential address.

The execute stage reports every resolved branch on a resolution stream: the branch address, whether it was taken, and where it actually went. These reports train the counters, refresh destinations and allocate entries for taken branches that have no entry yet. A separate redirect pair from execute carries a misprediction and the corrected address. It wins over any prediction in the same cycle.

Top module: `fetch_target_cache`

## Requirements
- R1: When the fetch address matches no valid entry and no redirect is requested, `pred_hit` and `pred_taken` are 0 and `next_pc` equals `fetch_pc + 4`.
- R2: When the fetch address matches a valid entry, `pred_hit` is 1. If that entry's counter is 2 or 3, `pred_taken` is 1 and `next_pc` is the stored destination. If the counter is 0 or 1, `pred_taken` is 0 and `next_pc` is `fetch_pc + 4`.
- R3: While `mispredict` is 1, `next_pc` equals `redirect_pc`, whatever the lookup result.
- R4: An accepted resolution allocates an entry only if it is taken and its address matches no valid entry. A not-taken resolution of an unknown address changes no entry.
- R5: A newly allocated entry stores the resolved destination and starts its counter at 2 (binary 10), so the next lookup of that address predicts taken.
- R6: A resolution that matches an entry adds 1 to that entry's counter when taken and subtracts 1 when not taken. The counter stops at 3 going up and at 0 going down.
- R7: A taken resolution that matches an entry overwrites the stored destination with the reported one. A not-taken resolution leaves the destination unchanged.
- R8: The buffer has 16 fully associative entries. An allocation takes the lowest-numbered invalid entry. When no entry is invalid, it replaces the entry named by a round-robin pointer. The pointer starts at 0 and advances by one, wrapping from 15 to 0, on each allocation into a full buffer.
- R9: While reset is asserted, and until a taken resolution has been accepted after reset, no lookup hits.
- R10: The resolution stream never back-pressures: `resolve_ready` is always 1. A resolution changes lookup results only from the cycle after it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fetch_pc | input | 32 | Address being fetched this cycle |
| next_pc | output | 32 | Address to fetch next cycle |
| pred_hit | output | 1 | Fetch address matched a valid entry |
| pred_taken | output | 1 | Matched entry predicts taken |
| resolve_valid | input | 1 | A resolved branch report is present |
| resolve_ready | output | 1 | Block accepts the report (always 1) |
| resolve_pc | input | 32 | Address of the resolved branch |
| resolve_taken | input | 1 | Branch outcome, 1 = taken |
| resolve_target | input | 32 | Actual destination of the branch |
| mispredict | input | 1 | Execute requests a fetch redirect |
| redirect_pc | input | 32 | Corrected fetch address |

## Verification
The assertions assume that reset is asserted at the start of the run, and that every input is a known value once reset has been released. This underlies the check that a hit needs a prior taken resolution. They do not assume that addresses are aligned or that redirects and resolutions are exclusive. The stimulus changes inputs only between clock edges. It holds reset for several cycles at the start and again before the capacity tests, and it drives redirects and resolutions both alone and together with lookups. Every report is mirrored into a bench model built from the requirements, and that model supplies the expected lookup outputs.

// File: rtl/ftc_pkg.sv
package ftc_pkg;
  localparam int PC_W = 32;
  typedef logic [PC_W-1:0] pc_t;
  typedef logic [1:0]      conf_t;
  localparam conf_t CONF_MAX     = 2'b11;
  localparam conf_t CONF_MIN     = 2'b00;
  localparam conf_t CONF_NEW     = 2'b10;
  localparam pc_t   SEQ_STEP     = pc_t'(4);

  typedef struct packed {
    logic  valid;
    pc_t   tag;
    conf_t conf;
    pc_t   dest;
  } slot_t;
endpackage

// File: rtl/ftc_match.sv
module ftc_match
  import ftc_pkg::*;
#(
  parameter int SLOTS = 16,
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  slot_t [SLOTS-1:0] slots,
  input  pc_t               key,
  output logic              hit,
  output logic [IW-1:0]     idx
);
  logic [SLOTS-1:0] eq;

  for (genvar s = 0; s < SLOTS; s++) begin : g_cmp
    assign eq[s] = slots[s].valid && (slots[s].tag == key);
  end

  always_comb begin
    idx = '0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (eq[s]) idx = IW'(s);
    end
  end

  assign hit = |eq;
endmodule

// File: rtl/ftc_store.sv
module ftc_store
  import ftc_pkg::*;
#(
  parameter int SLOTS = 16,
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              upd_valid,
  input  pc_t               upd_pc,
  input  logic              upd_taken,
  input  pc_t               upd_dest,
  input  logic              upd_hit,
  input  logic [IW-1:0]     upd_idx,
  output slot_t [SLOTS-1:0] slots
);
  logic [IW-1:0] rr_ptr;
  logic [IW-1:0] free_idx;
  logic          any_free;
  logic [IW-1:0] victim;
  logic          do_alloc;
  logic          do_train;

  always_comb begin
    free_idx = '0;
    any_free = 1'b0;
    for (int s = SLOTS - 1; s >= 0; s--) begin
      if (!slots[s].valid) begin
        free_idx = IW'(s);
        any_free = 1'b1;
      end
    end
  end

  assign victim   = any_free ? free_idx : rr_ptr;
  assign do_alloc = upd_valid && !upd_hit && upd_taken;
  assign do_train = upd_valid && upd_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rr_ptr <= '0;
    end else if (do_alloc && !any_free) begin
      rr_ptr <= (rr_ptr == IW'(SLOTS - 1)) ? '0 : rr_ptr + 1'b1;
    end
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic alloc_here;
    logic train_here;
    assign alloc_here = do_alloc && (victim == IW'(s));
    assign train_here = do_train && (upd_idx == IW'(s));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        slots[s] <= '0;
      end else if (alloc_here) begin
        slots[s].valid <= 1'b1;
        slots[s].tag   <= upd_pc;
        slots[s].conf  <= CONF_NEW;
        slots[s].dest  <= upd_dest;
      end else if (train_here) begin
        if (upd_taken) begin
          slots[s].dest <= upd_dest;
          if (slots[s].conf != CONF_MAX) slots[s].conf <= slots[s].conf + 1'b1;
        end else begin
          if (slots[s].conf != CONF_MIN) slots[s].conf <= slots[s].conf - 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fetch_target_cache.sv
module fetch_target_cache
  import ftc_pkg::*;
#(
  parameter int SLOTS = 16,
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [PC_W-1:0] fetch_pc,
  output logic [PC_W-1:0] next_pc,
  output logic            pred_hit,
  output logic            pred_taken,
  input  logic            resolve_valid,
  output logic            resolve_ready,
  input  logic [PC_W-1:0] resolve_pc,
  input  logic            resolve_taken,
  input  logic [PC_W-1:0] resolve_target,
  input  logic            mispredict,
  input  logic [PC_W-1:0] redirect_pc
);
  slot_t [SLOTS-1:0] slots;
  logic              f_hit;
  logic [IW-1:0]     f_idx;
  logic              r_hit;
  logic [IW-1:0]     r_idx;
  logic              accept;

  assign resolve_ready = 1'b1;
  assign accept        = resolve_valid && resolve_ready;

  ftc_match #(.SLOTS(SLOTS)) u_fetch_match (
    .slots (slots),
    .key   (fetch_pc),
    .hit   (f_hit),
    .idx   (f_idx)
  );

  ftc_match #(.SLOTS(SLOTS)) u_resolve_match (
    .slots (slots),
    .key   (resolve_pc),
    .hit   (r_hit),
    .idx   (r_idx)
  );

  ftc_store #(.SLOTS(SLOTS)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (accept),
    .upd_pc    (resolve_pc),
    .upd_taken (resolve_taken),
    .upd_dest  (resolve_target),
    .upd_hit   (r_hit),
    .upd_idx   (r_idx),
    .slots     (slots)
  );

  assign pred_hit   = f_hit;
  assign pred_taken = f_hit && slots[f_idx].conf[1];

  always_comb begin
    if (mispredict)      next_pc = redirect_pc;
    else if (pred_taken) next_pc = slots[f_idx].dest;
    else                 next_pc = fetch_pc + SEQ_STEP;
  end
endmodule

// File: rtl/ftc_checker.sv
module ftc_checker
  import ftc_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic [PC_W-1:0] fetch_pc,
  input logic [PC_W-1:0] next_pc,
  input logic            pred_hit,
  input logic            pred_taken,
  input logic            resolve_valid,
  input logic            resolve_ready,
  input logic            resolve_taken,
  input logic            mispredict,
  input logic [PC_W-1:0] redirect_pc
);
  logic taken_seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                            taken_seen <= 1'b0;
    else if (resolve_valid && resolve_ready && resolve_taken) taken_seen <= 1'b1;
  end

  // R3
  redirect_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mispredict |-> next_pc == redirect_pc);

  // R1
  miss_sequential_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pred_hit && !mispredict) |-> next_pc == fetch_pc + SEQ_STEP);

  // R2
  taken_needs_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_taken |-> pred_hit);

  // R2
  not_taken_sequential_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pred_hit && !pred_taken && !mispredict) |-> next_pc == fetch_pc + SEQ_STEP);

  // R9
  hit_after_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pred_hit |-> taken_seen);

  // R10
  never_stalls_chk: assert property (@(posedge clk) disable iff (!rst_n)
    resolve_valid |-> resolve_ready);
endmodule

bind fetch_target_cache ftc_checker u_ftc_checker (
  .clk           (clk),
  .rst_n         (rst_n),
  .fetch_pc      (fetch_pc),
  .next_pc       (next_pc),
  .pred_hit      (pred_hit),
  .pred_taken    (pred_taken),
  .resolve_valid (resolve_valid),
  .resolve_ready (resolve_ready),
  .resolve_taken (resolve_taken),
  .mispredict    (mispredict),
  .redirect_pc   (redirect_pc)
);

// File: tb/fetch_target_cache_test.sv
`timescale 1ns/1ps
module fetch_target_cache_test;
  localparam int N = 16;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic [31:0] next_pc;
  logic        pred_hit, pred_taken;
  logic        resolve_valid = 1'b0;
  logic        resolve_ready;
  logic [31:0] resolve_pc = '0;
  logic        resolve_taken = 1'b0;
  logic [31:0] resolve_target = '0;
  logic        mispredict = 1'b0;
  logic [31:0] redirect_pc = '0;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic        m_valid [N];
  logic [31:0] m_tag   [N];
  logic [1:0]  m_ctr   [N];
  logic [31:0] m_tgt   [N];
  int          m_rr;

  always #5 clk = ~clk;

  fetch_target_cache uut (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .next_pc(next_pc),
    .pred_hit(pred_hit), .pred_taken(pred_taken),
    .resolve_valid(resolve_valid), .resolve_ready(resolve_ready),
    .resolve_pc(resolve_pc), .resolve_taken(resolve_taken),
    .resolve_target(resolve_target), .mispredict(mispredict),
    .redirect_pc(redirect_pc)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < N; i++) begin
      m_valid[i] = 1'b0; m_tag[i] = '0; m_ctr[i] = '0; m_tgt[i] = '0;
    end
    m_rr = 0;
  endtask

  function automatic int model_find(input logic [31:0] pc);
    for (int i = 0; i < N; i++) if (m_valid[i] && m_tag[i] == pc) return i;
    return -1;
  endfunction

  task automatic model_update(input logic [31:0] pc, input logic t, input logic [31:0] tgt);
    int h, v;
    h = model_find(pc);
    if (h >= 0) begin
      if (t) begin
        m_tgt[h] = tgt;
        if (m_ctr[h] != 2'd3) m_ctr[h] = m_ctr[h] + 2'd1;
      end else if (m_ctr[h] != 2'd0) m_ctr[h] = m_ctr[h] - 2'd1;
    end else if (t) begin
      v = -1;
      for (int i = N - 1; i >= 0; i--) if (!m_valid[i]) v = i;
      if (v < 0) begin
        v = m_rr;
        m_rr = (m_rr + 1) % N;
      end
      m_valid[v] = 1'b1; m_tag[v] = pc; m_ctr[v] = 2'd2; m_tgt[v] = tgt;
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    model_clear();
    repeat (3) @(negedge clk);
    // R9: lookups during reset never hit
    fetch_pc = 32'h0000_0300;
    #1;
    check("R9 hit in reset", {31'd0, pred_hit}, 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // compare all lookup outputs against the model
  task automatic look(input string req, input logic [31:0] pc,
                      input logic mp = 1'b0, input logic [31:0] rpc = '0);
    int h;
    logic        e_hit, e_tk;
    logic [31:0] e_next;
    @(negedge clk);
    fetch_pc = pc; mispredict = mp; redirect_pc = rpc;
    h = model_find(pc);
    e_hit  = (h >= 0);
    e_tk   = e_hit && m_ctr[h][1];
    e_next = mp ? rpc : (e_tk ? m_tgt[h] : pc + 32'd4);
    #1;
    check({req, " hit"},   {31'd0, pred_hit},   {31'd0, e_hit});
    check({req, " taken"}, {31'd0, pred_taken}, {31'd0, e_tk});
    check({req, " next"},  next_pc, e_next);
    mispredict = 1'b0;
  endtask

  task automatic resolve(input logic [31:0] pc, input logic t, input logic [31:0] tgt);
    @(negedge clk);
    resolve_valid = 1'b1; resolve_pc = pc; resolve_taken = t; resolve_target = tgt;
    #1;
    check("R10 ready", {31'd0, resolve_ready}, 32'd1);
    @(posedge clk);
    model_update(pc, t, tgt);
    @(negedge clk);
    resolve_valid = 1'b0;
  endtask

  initial begin
    model_clear();
    do_reset();
    look("R9 after reset", 32'h0000_0100);
    look("R1 miss", 32'h0000_0300);

    // R4: not-taken unknown branch allocates nothing
    resolve(32'h0000_0200, 1'b0, 32'h0000_0800);
    look("R4 no alloc", 32'h0000_0200);

    // R10: a resolution is not visible in its own cycle
    @(negedge clk);
    resolve_valid = 1'b1; resolve_pc = 32'h0000_0300; resolve_taken = 1'b1;
    resolve_target = 32'h0000_1000; fetch_pc = 32'h0000_0300;
    #1;
    check("R10 same-cycle hit", {31'd0, pred_hit}, 32'd0);
    check("R10 same-cycle next", next_pc, 32'h0000_0304);
    @(posedge clk);
    model_update(32'h0000_0300, 1'b1, 32'h0000_1000);
    @(negedge clk);
    resolve_valid = 1'b0;
    // R5: new entry predicts taken to its destination
    look("R5 weak taken", 32'h0000_0300);
    check("R5 next", next_pc, 32'h0000_1000);

    // R6: saturate up, then walk down
    resolve(32'h0000_0300, 1'b1, 32'h0000_1000);
    resolve(32'h0000_0300, 1'b1, 32'h0000_1000);
    resolve(32'h0000_0300, 1'b1, 32'h0000_1000);
    resolve(32'h0000_0300, 1'b0, 32'h0000_0000);
    look("R6 sat high still taken", 32'h0000_0300);
    check("R6 taken after one N", {31'd0, pred_taken}, 32'd1);
    resolve(32'h0000_0300, 1'b0, 32'h0000_0000);
    look("R6 weak not taken", 32'h0000_0300);
    check("R2 hit not taken", {31'd0, pred_taken}, 32'd0);
    for (int k = 0; k < 4; k++) resolve(32'h0000_0300, 1'b0, 32'h0000_0000);
    resolve(32'h0000_0300, 1'b1, 32'h0000_2000);
    look("R6 sat low one T", 32'h0000_0300);
    check("R6 not taken after one T", {31'd0, pred_taken}, 32'd0);
    resolve(32'h0000_0300, 1'b1, 32'h0000_2000);
    look("R7 new target", 32'h0000_0300);
    check("R7 target overwritten", next_pc, 32'h0000_2000);
    resolve(32'h0000_0300, 1'b0, 32'h0000_3000);
    resolve(32'h0000_0300, 1'b1, 32'h0000_2000);
    resolve(32'h0000_0300, 1'b1, 32'h0000_2000);
    resolve(32'h0000_0300, 1'b0, 32'h0000_5000);
    look("R7 not-taken keeps target", 32'h0000_0300);
    check("R7 target kept", next_pc, 32'h0000_2000);

    // R3: redirect beats both hit and miss
    look("R3 redirect on hit", 32'h0000_0300, 1'b1, 32'h0000_ABC0);
    look("R3 redirect on miss", 32'h0000_0900, 1'b1, 32'h0000_0040);

    // R8: fill, then round-robin eviction
    do_reset();
    for (int i = 0; i < N; i++) resolve(32'h0000_4000 + 32'(i * 16), 1'b1, 32'h0001_0000 + 32'(i * 4));
    for (int i = 0; i < N; i++) look("R8 full", 32'h0000_4000 + 32'(i * 16));
    resolve(32'h0000_9000, 1'b1, 32'h0002_0000);
    look("R8 evict slot 0", 32'h0000_4000);
    check("R8 slot 0 gone", {31'd0, pred_hit}, 32'd0);
    look("R8 newcomer", 32'h0000_9000);
    resolve(32'h0000_9100, 1'b1, 32'h0002_0004);
    look("R8 evict slot 1", 32'h0000_4010);
    check("R8 slot 1 gone", {31'd0, pred_hit}, 32'd0);
    look("R8 slot 2 kept", 32'h0000_4020);

    // sweep: pseudo-random reports over 24 addresses, full lookup scan each time
    do_reset();
    begin
      logic [31:0] lfsr;
      lfsr = 32'h1234_5677;
      for (int n = 0; n < 300; n++) begin
        lfsr = lfsr * 32'd1664525 + 32'd1013904223;
        resolve(32'h0000_8000 + 32'((lfsr[27:20] % 24) * 8), lfsr[13] | lfsr[14],
                32'h0003_0000 + {20'd0, lfsr[11:2], 2'b00});
        for (int a = 0; a < 24; a++)
          look("R2 R6 R8 sweep", 32'h0000_8000 + 32'(a * 8), 1'b0, 32'd0);
      end
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    #1_500_000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule